// File: doc/BRIEF.md
# PCM Channel Byte Coding Translator

This block recodes one 8-bit channel byte as it travels from a receive time slot to a transmit time slot of a TDM switch. Each byte arrives with its own per-channel settings. A mode flag selects voice or data handling. In voice mode, a receive law code and a transmit law code each name one of four companding variants. In data mode, a 2-bit code selects one of four fixed bit-inversion patterns.

In voice mode, when the two law codes name the same companding law, only the line inversion is changed. When they name different laws, the byte is expanded to a linear magnitude, rescaled, and compressed again into the other law. The sign is carried across unchanged. The datapath takes one byte per valid strobe, has one register stage and no backpressure. The result of a strobe appears exactly one clock after it.

A byte is seen in two forms. The canonical form is sign (1 = positive), then a 3-bit segment, then a 4-bit step. The line form is the canonical form XORed with a variant mask. The A-law masks are 0x55 for the standard variant and 0x00 for the variant without alternate bit inversion. The µ-law masks are 0x7F for the standard variant and 0x00 for the variant without magnitude inversion.

Top module: `pcm_xlat`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_valid is 0 and out_byte is 0x00.
- R2: out_valid equals in_valid of the previous clock. When in_valid is 0, out_byte keeps its previous value.
- R3: With dat_mode = 1, out_byte is in_byte XOR a mask chosen by dat_code: 00 → 0x00, 01 → 0x55, 10 → 0xAA, 11 → 0xFF.
- R4: With dat_mode = 0, law codes are 00 = A-law standard (mask 0x55), 01 = µ-law standard (mask 0x7F), 10 = A-law without alternate inversion (mask 0x00), 11 = µ-law without magnitude inversion (mask 0x00). Bit 0 of a code is 1 for µ-law. If rx_law equals tx_law, out_byte equals in_byte bit-exact.
- R5: With dat_mode = 0 and both codes naming the same law but different variants, out_byte = in_byte XOR mask(rx_law) XOR mask(tx_law).
- R6: For A-law to µ-law, the canonical A magnitude code (segment e, step m) expands to L = 2m+1 when e = 0, otherwise L = (2m+33)·2^(e-1). The µ-law output is the code whose interval holds 2L. µ-law code (e,m) covers values v where (2m+32)·2^e − 33 ≤ v < (2m+34)·2^e − 33. The sign is copied.
- R7: For µ-law to A-law, the canonical µ magnitude code expands to V = (2m+33)·2^e − 33. The A-law output is the code whose interval holds floor(V/2). A-law code (e,m) covers [2m, 2m+2) when e = 0, and [(16+m)·2^e, (17+m)·2^e) otherwise. The sign is copied.
- R8: In data mode the law codes have no effect on out_byte. In voice mode dat_code has no effect on out_byte.
- R9: Passing a byte from one variant to the other variant of the same law, and then back, returns the original byte for all 256 values. Applying the same data code twice also returns the original byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: in_byte and its settings are taken this cycle |
| in_byte | input | 8 | Received channel byte |
| dat_mode | input | 1 | 0 = voice coding, 1 = data coding |
| rx_law | input | 2 | Companding variant of in_byte (voice mode) |
| tx_law | input | 2 | Companding variant wanted at out_byte (voice mode) |
| dat_code | input | 2 | Inversion pattern (data mode) |
| out_valid | output | 1 | Strobe delayed by one clock |
| out_byte | output | 8 | Recoded byte, held between strobes |

## Verification
The properties assume that every setting is a known value whenever in_valid is high, and that the settings belong to the same cycle as their byte. There is no separate configuration timing. The bench changes inputs only on the falling clock edge and always presents a byte with its settings together. It sweeps all 256 byte values against every law pair and every data code. It also uses idle gaps to check that the output is held, and applies a second pass through the opposite variant to check the round trip.

// File: rtl/pcm_xlat_pkg.sv
package pcm_xlat_pkg;

   localparam int BYTE_W = 8;
   localparam int SEG_W  = 3;
   localparam int STEP_W = 4;
   localparam int MAG_W  = SEG_W + STEP_W;

   typedef enum logic [1:0] {
      LAW_A_STD = 2'b00,
      LAW_U_STD = 2'b01,
      LAW_A_RAW = 2'b10,
      LAW_U_RAW = 2'b11
   } law_code_e;

   typedef enum logic [1:0] {
      DAT_PLAIN = 2'b00,
      DAT_ALT   = 2'b01,
      DAT_IALT  = 2'b10,
      DAT_ALL   = 2'b11
   } dat_code_e;

   function automatic logic law_is_mu(input logic [1:0] code);
      return code[0];
   endfunction

   function automatic logic [BYTE_W-1:0] law_mask(input logic [1:0] code,
                                                  input logic [BYTE_W-1:0] a_mask,
                                                  input logic [BYTE_W-1:0] u_mask);
      case (code)
         LAW_A_STD: return a_mask;
         LAW_U_STD: return u_mask;
         default:   return '0;
      endcase
   endfunction

   function automatic logic [BYTE_W-1:0] dat_mask(input logic [1:0] code,
                                                  input logic [BYTE_W-1:0] alt_mask);
      case (code)
         DAT_PLAIN: return '0;
         DAT_ALT:   return alt_mask;
         DAT_IALT:  return ~alt_mask;
         default:   return '1;
      endcase
   endfunction

endpackage

// File: rtl/pcm_expand.sv
module pcm_expand
   import pcm_xlat_pkg::*;
#(
   parameter int LIN_W  = 14,
   parameter bit MU_LAW = 1'b0
) (
   input  logic [MAG_W-1:0] mag_code,
   output logic [LIN_W-1:0] lin
);
   localparam logic [LIN_W-1:0] SEG_BASE = LIN_W'(32);
   localparam logic [LIN_W-1:0] MU_BIAS  = LIN_W'(33);

   logic [SEG_W-1:0]  seg;
   logic [STEP_W:0]   odd_step;
   logic [LIN_W-1:0]  body;

   assign seg      = mag_code[MAG_W-1:STEP_W];
   assign odd_step = {mag_code[STEP_W-1:0], 1'b1};
   assign body     = LIN_W'(odd_step) + SEG_BASE;

   generate
      if (MU_LAW) begin : g_mu
         assign lin = (body << seg) - MU_BIAS;
      end else begin : g_a
         always_comb begin
            if (seg == '0) lin = LIN_W'(odd_step);
            else           lin = body << (seg - SEG_W'(1));
         end
      end
   endgenerate
endmodule

// File: rtl/pcm_compress.sv
module pcm_compress
   import pcm_xlat_pkg::*;
#(
   parameter int LIN_W  = 14,
   parameter bit MU_LAW = 1'b0
) (
   input  logic [LIN_W-1:0] lin,
   output logic [MAG_W-1:0] mag_code
);
   localparam int TOP_SEG  = (1 << SEG_W) - 1;
   localparam int U_LOWMSB = STEP_W + 1;
   localparam int A_LOWMSB = STEP_W;

   generate
      if (MU_LAW) begin : g_mu
         logic [LIN_W:0] biased;
         int             msb;
         int             seg;
         assign biased = {1'b0, lin} + (LIN_W+1)'(33);
         always_comb begin
            msb = 0;
            for (int i = 0; i <= LIN_W; i++) begin
               if (biased[i]) msb = i;
            end
            seg = msb - U_LOWMSB;
            if (seg > TOP_SEG) mag_code = '1;
            else mag_code = {SEG_W'(seg), STEP_W'(biased >> (seg + 1))};
         end
      end else begin : g_a
         int msb;
         int seg;
         always_comb begin
            msb = 0;
            for (int i = 0; i < LIN_W; i++) begin
               if (lin[i]) msb = i;
            end
            seg = msb - A_LOWMSB;
            if (seg > TOP_SEG)       mag_code = '1;
            else if (seg < 1)        mag_code = {SEG_W'(0), STEP_W'(lin >> 1)};
            else                     mag_code = {SEG_W'(seg), STEP_W'(lin >> seg)};
         end
      end
   endgenerate
endmodule

// File: rtl/pcm_xlat.sv
module pcm_xlat
   import pcm_xlat_pkg::*;
#(
   parameter int                LIN_W    = 14,
   parameter logic [BYTE_W-1:0] A_MASK   = 8'h55,
   parameter logic [BYTE_W-1:0] U_MASK   = 8'h7F,
   parameter logic [BYTE_W-1:0] ALT_MASK = 8'h55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_byte,
   input  logic              dat_mode,
   input  logic [1:0]        rx_law,
   input  logic [1:0]        tx_law,
   input  logic [1:0]        dat_code,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_byte
);
   localparam int MIN_LIN_W = 14;

   generate
      if (LIN_W < MIN_LIN_W) begin : g_bad_lin
         $error("pcm_xlat: LIN_W must hold the 14-bit linear range");
      end
      if (U_MASK[BYTE_W-1]) begin : g_bad_umask
         $error("pcm_xlat: U_MASK must leave the sign bit untouched");
      end
   endgenerate

   logic [BYTE_W-1:0] canon;
   logic [LIN_W-1:0]  lin_from_a, lin_from_u;
   logic [LIN_W-1:0]  lin_to_u, lin_to_a;
   logic [MAG_W-1:0]  code_as_u, code_as_a;
   logic [BYTE_W-1:0] next_byte;

   assign canon = in_byte ^ law_mask(rx_law, A_MASK, U_MASK);

   pcm_expand #(.LIN_W(LIN_W), .MU_LAW(1'b0)) u_exp_a (
      .mag_code (canon[MAG_W-1:0]),
      .lin      (lin_from_a)
   );
   pcm_expand #(.LIN_W(LIN_W), .MU_LAW(1'b1)) u_exp_u (
      .mag_code (canon[MAG_W-1:0]),
      .lin      (lin_from_u)
   );

   assign lin_to_u = lin_from_a << 1;
   assign lin_to_a = lin_from_u >> 1;

   pcm_compress #(.LIN_W(LIN_W), .MU_LAW(1'b1)) u_cmp_u (
      .lin      (lin_to_u),
      .mag_code (code_as_u)
   );
   pcm_compress #(.LIN_W(LIN_W), .MU_LAW(1'b0)) u_cmp_a (
      .lin      (lin_to_a),
      .mag_code (code_as_a)
   );

   always_comb begin
      if (dat_mode)
         next_byte = in_byte ^ dat_mask(dat_code, ALT_MASK);
      else if (rx_law == tx_law)
         next_byte = in_byte;
      else if (law_is_mu(rx_law) == law_is_mu(tx_law))
         next_byte = canon ^ law_mask(tx_law, A_MASK, U_MASK);
      else if (law_is_mu(rx_law))
         next_byte = {canon[BYTE_W-1], code_as_a} ^ law_mask(tx_law, A_MASK, U_MASK);
      else
         next_byte = {canon[BYTE_W-1], code_as_u} ^ law_mask(tx_law, A_MASK, U_MASK);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_byte  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_byte <= next_byte;
      end
   end
endmodule

// File: rtl/pcm_xlat_chk.sv
module pcm_xlat_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic [7:0] in_byte,
   input logic       dat_mode,
   input logic [1:0] rx_law,
   input logic [1:0] tx_law,
   input logic [1:0] dat_code,
   input logic       out_valid,
   input logic [7:0] out_byte
);
   p_strobe_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_strobe_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_byte));
   p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !dat_mode && rx_law == tx_law) |=> out_byte == $past(in_byte));
   p_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dat_mode && dat_code == 2'b00) |=> out_byte == $past(in_byte));
   p_allinv_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dat_mode && dat_code == 2'b11) |=> out_byte == ~$past(in_byte));
   p_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !dat_mode && rx_law == 2'b10 && tx_law == 2'b11)
      |=> out_byte[7] == $past(in_byte[7]));
endmodule

bind pcm_xlat pcm_xlat_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_byte   (in_byte),
   .dat_mode  (dat_mode),
   .rx_law    (rx_law),
   .tx_law    (tx_law),
   .dat_code  (dat_code),
   .out_valid (out_valid),
   .out_byte  (out_byte)
);

// File: tb/sim_pcm_xlat.sv
module sim_pcm_xlat;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       dat_mode = 1'b0;
   logic [1:0] rx_law = 2'b00;
   logic [1:0] tx_law = 2'b00;
   logic [1:0] dat_code = 2'b00;
   logic       out_valid;
   logic [7:0] out_byte;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   pcm_xlat u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .dat_mode(dat_mode), .rx_law(rx_law), .tx_law(tx_law), .dat_code(dat_code),
      .out_valid(out_valid), .out_byte(out_byte)
   );

   function automatic int vmask(input int code);
      case (code)
         0: return 'h55;
         1: return 'h7F;
         default: return 0;
      endcase
   endfunction

   function automatic int dmask(input int code);
      case (code)
         0: return 'h00;
         1: return 'h55;
         2: return 'hAA;
         default: return 'hFF;
      endcase
   endfunction

   // centre value and half interval of a magnitude code
   function automatic int a_mid(input int k);
      int e = k / 16; int m = k % 16;
      if (e == 0) return 2 * m + 1;
      return (16 << e) + m * (1 << e) + (1 << (e - 1));
   endfunction
   function automatic int a_half(input int k);
      int e = k / 16;
      return (e == 0) ? 1 : (1 << (e - 1));
   endfunction
   function automatic int u_mid(input int k);
      int e = k / 16; int m = k % 16;
      return m * (2 << e) + 33 * (1 << e) - 33;
   endfunction
   function automatic int u_half(input int k);
      return 1 << (k / 16);
   endfunction

   function automatic int pick_a(input int v);
      int best = 0;
      for (int k = 0; k < 128; k++) if (a_mid(k) - a_half(k) <= v) best = k;
      return best;
   endfunction
   function automatic int pick_u(input int v);
      int best = 0;
      for (int k = 0; k < 128; k++) if (u_mid(k) - u_half(k) <= v) best = k;
      return best;
   endfunction

   function automatic int model(input int b, input int dm, input int rl,
                                input int tl, input int dc);
      int c, s, k;
      if (dm != 0) return b ^ dmask(dc);
      if (rl == tl) return b;
      c = b ^ vmask(rl);
      if ((rl % 2) == (tl % 2)) return c ^ vmask(tl);
      s = c & 'h80;
      if ((rl % 2) == 1) k = pick_a(u_mid(c & 'h7F) / 2);
      else               k = pick_u(2 * a_mid(c & 'h7F));
      return (s | k) ^ vmask(tl);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic put(input int b, input int dm, input int rl, input int tl, input int dc);
      in_valid = 1'b1; in_byte = 8'(b); dat_mode = dm[0];
      rx_law = 2'(rl); tx_law = 2'(tl); dat_code = 2'(dc);
      @(negedge clk);
   endtask

   function automatic string tag_of(input int dm, input int rl, input int tl);
      if (dm != 0) return "R3/R8";
      if (rl == tl) return "R4/R8";
      if ((rl % 2) == (tl % 2)) return "R5";
      if ((rl % 2) == 1) return "R7";
      return "R6";
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int hold;
      int mid;
      repeat (3) @(negedge clk);
      check("R1 valid", int'(out_valid), 0);
      check("R1 byte", int'(out_byte), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid after release", int'(out_valid), 0);
      check("R1 byte after release", int'(out_byte), 0);

      // voice sweep, data code varied (ignored)
      for (int rl = 0; rl < 4; rl++)
         for (int tl = 0; tl < 4; tl++)
            for (int b = 0; b < 256; b++) begin
               put(b, 0, rl, tl, b % 4);
               check({tag_of(0, rl, tl), " strobe R2"}, int'(out_valid), 1);
               check(tag_of(0, rl, tl), int'(out_byte), model(b, 0, rl, tl, 0));
            end

      // data sweep, law codes varied (ignored)
      for (int dc = 0; dc < 4; dc++)
         for (int b = 0; b < 256; b++) begin
            put(b, 1, b % 4, (b / 4) % 4, dc);
            check(tag_of(1, 0, 0), int'(out_byte), model(b, 1, 0, 0, dc));
         end

      // idle gap: output held, strobe low
      hold = int'(out_byte);
      in_valid = 1'b0; in_byte = 8'h3C; dat_mode = 1'b1; dat_code = 2'b11;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R2 idle valid", int'(out_valid), 0);
         check("R2 idle hold", int'(out_byte), hold);
      end

      // round trips through the opposite variant and back
      for (int pair = 0; pair < 2; pair++)
         for (int b = 0; b < 256; b++) begin
            put(b, 0, pair, pair + 2, 0);
            mid = int'(out_byte);
            put(mid, 0, pair + 2, pair, 0);
            check("R9 law round trip", int'(out_byte), b);
         end
      for (int dc = 0; dc < 4; dc++)
         for (int b = 0; b < 256; b += 7) begin
            put(b, 1, 0, 0, dc);
            mid = int'(out_byte);
            put(mid, 1, 0, 0, dc);
            check("R9 data round trip", int'(out_byte), b);
         end

      in_valid = 1'b0;
      @(negedge clk);
      check("R2 final strobe", int'(out_valid), 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule